// File: doc/BRIEF.md
# Banked Register File with Indirect Addressing

This block is the byte-wide data store of a small 8-bit controller core. It holds 256 byte locations arranged as two banks of 128. One bit inside the store's own status byte picks the active bank. Most offsets are shared, so both banks reach the same byte. Five special offsets (0x01, 0x05, 0x06, 0x08, 0x09) keep a separate copy in each bank. Offset 0x00 is virtual and has no storage behind it. Any access to it is forwarded to the byte whose full 8-bit address sits in the pointer byte at 0x04.

The core reads through a combinational port and writes through a synchronous port. Both ports take 7-bit direct addresses. Three flag bits in the status byte (carry, digit carry, zero) have their own set and clear inputs, so the ALU can update them without a read-modify-write. The three flags also come out on their own output.

Top module: `banked_regfile`

## Requirements
- R1: After reset every location reads 0x00, bank 0 is selected (`bank_o`=0) and `flags_o`=0.
- R2: Bit 5 of the status byte at offset 0x03 selects the bank: 0 selects bank 0 and 1 selects bank 1. A direct access to one of the offsets 0x01, 0x05, 0x06, 0x08, 0x09 reaches location {bank,offset}, so each bank has its own copy of these bytes.
- R3: A direct access to any other nonzero offset reaches location {0,offset} whatever the bank bit is. These bytes, the status byte and the pointer byte included, are mirrored across both banks.
- R4: A direct access to offset 0x00 is redirected through the 8-bit pointer held at offset 0x04.
- R5: When the low 7 bits of the pointer are one of the bank-unique offsets, the indirect access reaches the exact location the pointer names (0x01..0x09 or 0x81..0x89), whatever the bank bit is.
- R6: Any other pointer value whose low 7 bits are nonzero reaches location (pointer mod 128).
- R7: A pointer whose low 7 bits are zero (0x00 or 0x80) reads as 0x00, and a write through it changes no location.
- R8: `flag_set`/`flag_clr` bit 0 acts on carry (status bit 0), bit 1 on digit carry (status bit 1) and bit 2 on zero (status bit 2). Each acts on its own bit only and takes effect at the next clock edge. If set and clear reach the same bit in one cycle, set wins. `flags_o` shows status bits 2..0.
- R9: If a flag request and a write that resolves to the status byte happen in the same cycle, the flag request decides its bit and the written data decides all other bits.
- R10: A write updates exactly one resolved location. The byte read back through any address that resolves elsewhere does not change.
- R11: `rd_data` is combinational. It shows a write in the cycle after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 7 | Direct read address |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Direct write address |
| wr_data | input | 8 | Write data |
| flag_set | input | 3 | Set requests for zero, digit carry, carry (bits 2..0) |
| flag_clr | input | 3 | Clear requests for zero, digit carry, carry (bits 2..0) |
| flags_o | output | 3 | Current zero, digit carry, carry |
| bank_o | output | 1 | Current bank select |

## Verification
The assertions take for granted that the write and flag inputs are steady across each rising edge. They also assume that any combination of set and clear on the same flag bit is allowed, and that nothing but the write port and the flag inputs changes the status byte. The bench changes inputs only on the falling edge. Its stimulus draws from every input pattern, including set and clear on one bit together, writes into the status byte that flip the bank mid-sequence, and pointer values at 0x00, 0x80 and the bank-unique addresses. All of these fall inside the assumed input space.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DW        = 8;
  localparam int AW        = 7;
  localparam int IW        = AW + 1;
  localparam int DEPTH     = 1 << IW;
  localparam int NFLAG     = 3;
  localparam int NUNIQ     = 5;
  localparam int BANK_BIT  = 5;
  localparam logic [AW-1:0] VIRT_OFF   = 7'h00;
  localparam logic [AW-1:0] STATUS_OFF = 7'h03;
  localparam logic [AW-1:0] PTR_OFF    = 7'h04;
  localparam logic [AW-1:0] UNIQ_OFF [NUNIQ] = '{7'h01, 7'h05, 7'h06, 7'h08, 7'h09};

  typedef logic [DW-1:0] byte_t;
  typedef logic [IW-1:0] idx_t;
  typedef logic [AW-1:0] off_t;

  typedef struct packed {
    idx_t idx;
    logic nul;
  } route_t;

  function automatic logic is_uniq(input off_t off);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NUNIQ; k++) begin
      if (off == UNIQ_OFF[k]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic idx_t direct_idx(input off_t off, input logic bank);
    return (bank && is_uniq(off)) ? {1'b1, off} : {1'b0, off};
  endfunction

  function automatic route_t via_ptr(input byte_t ptr);
    route_t r;
    r.nul = (ptr[AW-1:0] == VIRT_OFF);
    r.idx = is_uniq(ptr[AW-1:0]) ? idx_t'(ptr) : {1'b0, ptr[AW-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve
  import rf_pkg::*;
(
  input  logic [AW-1:0] off,
  input  logic          bank,
  input  logic [DW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          nul
);
  route_t ind;
  logic   is_virt;

  assign is_virt = (off == VIRT_OFF);
  assign ind     = via_ptr(ptr);
  assign idx     = is_virt ? ind.idx : direct_idx(off, bank);
  assign nul     = is_virt & ind.nul;

  // a resolved index in the upper bank must be a bank-unique offset (R5, R2)
  always_comb begin
    if (idx[IW-1] && !nul) begin
      assert (is_uniq(idx[AW-1:0]))
        else $error("upper bank index on mirrored offset");
    end
  end
endmodule

// File: rtl/rf_flag_merge.sv
module rf_flag_merge
  import rf_pkg::*;
(
  input  logic [DW-1:0]    cur,
  input  logic             wr_hit,
  input  logic [DW-1:0]    wr_data,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [DW-1:0]    nxt
);
  logic [DW-1:0] base;
  assign base = wr_hit ? wr_data : cur;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign nxt[g] = set[g] ? 1'b1 : (clr[g] ? 1'b0 : base[g]);
  end
  assign nxt[DW-1:NFLAG] = base[DW-1:NFLAG];
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] status_nxt,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_byte,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] ptr_q
);
  localparam idx_t STATUS_IDX = {1'b0, STATUS_OFF};
  localparam idx_t PTR_IDX    = {1'b0, PTR_OFF};

  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we && wr_idx != STATUS_IDX) mem[wr_idx] <= wr_data;
      mem[STATUS_IDX] <= status_nxt;
    end
  end

  assign rd_byte  = mem[rd_idx];
  assign status_q = mem[STATUS_IDX];
  assign ptr_q    = mem[PTR_IDX];

  // a committed write lands at its resolved index (R10, R11)
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_idx != STATUS_IDX) |=> (mem[$past(wr_idx)] == $past(wr_data)));

  // the status byte follows its merged next value (R9)
  p_status_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem[STATUS_IDX] == $past(status_nxt)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags_o,
  output logic             bank_o
);
  localparam idx_t STATUS_IDX = {1'b0, STATUS_OFF};

  logic [DW-1:0] status_q, ptr_q, status_nxt, rd_byte;
  logic [IW-1:0] rd_idx, wr_idx;
  logic          rd_nul, wr_nul, wr_go, wr_status_hit, flag_any;

  assign bank_o = status_q[BANK_BIT];

  rf_addr_resolve u_rd_res (
    .off(rd_addr), .bank(bank_o), .ptr(ptr_q), .idx(rd_idx), .nul(rd_nul)
  );

  rf_addr_resolve u_wr_res (
    .off(wr_addr), .bank(bank_o), .ptr(ptr_q), .idx(wr_idx), .nul(wr_nul)
  );

  assign wr_go         = wr_en & ~wr_nul;
  assign wr_status_hit = wr_go & (wr_idx == STATUS_IDX);
  assign flag_any      = |(flag_set | flag_clr);

  rf_flag_merge u_merge (
    .cur(status_q), .wr_hit(wr_status_hit), .wr_data(wr_data),
    .set(flag_set), .clr(flag_clr), .nxt(status_nxt)
  );

  rf_store u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .wr_idx(wr_idx), .wr_data(wr_data),
    .status_nxt(status_nxt), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .status_q(status_q), .ptr_q(ptr_q)
  );

  assign rd_data = rd_nul ? '0 : rd_byte;
  assign flags_o = status_q[NFLAG-1:0];

  // set request wins for its flag on the next edge (R8, R9)
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[0] |=> flags_o[0]);

  // clear without set drops the flag on the next edge (R8, R9)
  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[2] && !flag_set[2]) |=> !flags_o[2]);

  // status holds when neither a status write nor a flag request occurs (R8)
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_status_hit && !flag_any) |=> $stable(status_q));

  // a write through a null pointer leaves the pointer byte alone (R7)
  p_null_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_nul) |=> $stable(ptr_q));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic [2:0] flag_set = '0, flag_clr = '0;
  wire  [7:0] rd_data;
  wire  [2:0] flags_o;
  wire        bank_o;

  int total = 0;
  int bad = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_set(flag_set), .flag_clr(flag_clr), .flags_o(flags_o), .bank_o(bank_o)
  );

  // stimulus vectors: {wen, waddr, wdata, raddr, expected read before the edge}
  typedef struct packed {
    logic       we;
    logic [6:0] wa;
    logic [7:0] wd;
    logic [6:0] ra;
    logic [7:0] ex;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 7'h03, 8'h20, 7'h03, 8'h00},  // R2 go to bank 1
    '{1'b1, 7'h05, 8'h11, 7'h03, 8'h20},  // R2 write upper copy
    '{1'b1, 7'h03, 8'h00, 7'h05, 8'h11},  // R2 read upper copy
    '{1'b1, 7'h05, 8'h33, 7'h05, 8'h00},  // R2 lower copy still clear
    '{1'b1, 7'h04, 8'h85, 7'h05, 8'h33},  // R3 pointer write
    '{1'b1, 7'h20, 8'h44, 7'h00, 8'h11},  // R5 pointer 0x85 from bank 0
    '{1'b1, 7'h04, 8'hA0, 7'h20, 8'h44},  // R11
    '{1'b1, 7'h00, 8'h55, 7'h00, 8'h44},  // R6 0xA0 -> 0x20
    '{1'b0, 7'h00, 8'h00, 7'h20, 8'h55},  // R4 write through virtual
    '{1'b1, 7'h04, 8'h80, 7'h00, 8'h55},
    '{1'b1, 7'h00, 8'h77, 7'h00, 8'h00},  // R7 null pointer read
    '{1'b0, 7'h00, 8'h00, 7'h20, 8'h55}   // R7 null write had no effect
  };

  function automatic logic uniq_off(input logic [6:0] o);
    case (o)
      7'h01, 7'h05, 7'h06, 7'h08, 7'h09: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // returns 9 bits: {null, index}
  function automatic logic [8:0] where(input logic [6:0] a);
    logic [7:0] p;
    if (a != 7'h00) begin
      if (uniq_off(a) && model[3][5]) return {1'b0, 8'h80 + 8'(a)};
      return {1'b0, 8'(a)};
    end
    p = model[4];
    if ((p % 128) == 0) return {1'b1, 8'h00};
    if (uniq_off(p[6:0])) return {1'b0, p};
    return {1'b0, 8'(p % 128)};
  endfunction

  function automatic logic [7:0] model_read(input logic [6:0] a);
    logic [8:0] w;
    w = where(a);
    return w[8] ? 8'h00 : model[w[7:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare read, commit at rising edge
  task automatic cycle(input logic we, input logic [6:0] wa, input logic [7:0] wd,
                       input logic [6:0] ra, input logic [2:0] fs, input logic [2:0] fc,
                       input string req);
    logic [8:0] w;
    logic [7:0] st;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    flag_set = fs; flag_clr = fc;
    #1;
    check(req, rd_data, model_read(ra));
    w  = where(wa);
    st = model[3];
    if (we && !w[8]) begin
      if (w[7:0] == 8'h03) st = wd;
      else model[w[7:0]] = wd;
    end
    for (int b = 0; b < 3; b++) begin
      if (fs[b]) st[b] = 1'b1;
      else if (fc[b]) st[b] = 1'b0;
    end
    @(posedge clk);
    model[3] = st;
    @(negedge clk);
    wr_en = 1'b0; flag_set = '0; flag_clr = '0;
    #1;
    check(req, {bank_o, flags_o}, {model[3][5], model[3][2:0]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0; flag_set = '0; flag_clr = '0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", {bank_o, flags_o}, 4'h0);
    for (int a = 1; a < 16; a++) begin
      rd_addr = 7'(a); #1;
      check("R1", rd_data, 8'h00);
    end

    // table walk
    for (int i = 0; i < 12; i++) begin
      wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_data = VEC[i].wd; rd_addr = VEC[i].ra;
      #1;
      check("R2 R4 R5 R6 R7 R11 table", rd_data, VEC[i].ex);
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R9 flag request against status write
    do_reset();
    cycle(1'b1, 7'h03, 8'h00, 7'h03, 3'b101, 3'b000, "R9");
    rd_addr = 7'h03; #1; check("R9", rd_data, 8'h05);
    cycle(1'b1, 7'h03, 8'hFF, 7'h03, 3'b000, 3'b010, "R9");
    rd_addr = 7'h03; #1; check("R9", rd_data, 8'hFD);
    // R8 set wins over clear, other bits untouched
    cycle(1'b0, 7'h00, 8'h00, 7'h03, 3'b001, 3'b001, "R8");
    cycle(1'b0, 7'h00, 8'h00, 7'h03, 3'b000, 3'b111, "R8");
    rd_addr = 7'h03; #1; check("R8", rd_data, 8'hF8);
    check("R8", bank_o, 1'b1);

    // R10 indirect write to upper unique copy leaves lower copy alone
    cycle(1'b1, 7'h08, 8'hC3, 7'h08, 3'b000, 3'b000, "R10");  // bank 1 -> 0x88
    cycle(1'b1, 7'h03, 8'h00, 7'h08, 3'b000, 3'b000, "R10");
    cycle(1'b1, 7'h08, 8'h3C, 7'h08, 3'b000, 3'b000, "R10");  // bank 0 -> 0x08
    cycle(1'b1, 7'h04, 8'h88, 7'h08, 3'b000, 3'b000, "R10");
    cycle(1'b1, 7'h00, 8'h99, 7'h00, 3'b000, 3'b000, "R10");
    rd_addr = 7'h08; #1; check("R10", rd_data, 8'h3C);
    rd_addr = 7'h00; #1; check("R10", rd_data, 8'h99);
    // R3 mirrored offset same in both banks
    cycle(1'b1, 7'h0C, 8'h5A, 7'h0C, 3'b000, 3'b000, "R3");
    cycle(1'b1, 7'h03, 8'h20, 7'h0C, 3'b000, 3'b000, "R3");
    rd_addr = 7'h0C; #1; check("R3", rd_data, 8'h5A);

    // random mix against model
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] wa, ra;
      logic [7:0] wd;
      wa = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 10)) : 7'($urandom);
      ra = ($urandom_range(0, 2) == 0) ? 7'($urandom_range(0, 10)) : 7'($urandom);
      wd = 8'($urandom);
      if (wa == 7'h04 && $urandom_range(0, 1) == 1) wd = {wd[7], 7'($urandom_range(0, 10))};
      cycle(1'($urandom), wa, wd, ra, 3'($urandom) & 3'($urandom),
            3'($urandom) & 3'($urandom), "R2 R3 R5 R6 R7 R10 random");
    end

    // R1 reset again mid-run
    do_reset();
    check("R1", {bank_o, flags_o}, 4'h0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 7'(a); #1;
      check("R1", rd_data, 8'h00);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule